// File: doc/BRIEF.md
# Complementary PWM Output Control Stage

This block turns one channel's internal reference waveform into a main output and a complementary output. Each output has its own drive-enable flag, so the pad logic can tri-state it. A master enable chooses between run behaviour and idle behaviour. In run mode, each output follows the reference through its own enable and polarity bit. When both outputs are enabled, a fixed dead-time window is inserted at each reference edge. A run-mode off-state select decides whether a disabled output floats or is held at its inactive level.

When the master enable drops, an idle off-state select either releases both pins or drives them. If it drives them, the pins are first forced at once to their polarity levels. After the dead-time count they move to per-output idle levels.

The enable and polarity bits are written through a preload register. They reach the working copy either one clock after the write or, with commutation preload set, only on a commutation pulse. A lock level protects the polarity bits against writes.

Top module: `cpwm_out_stage`

## Requirements
- R1: After synchronous reset, all preload and working enable/polarity bits are 0. With master enable and idle select both low, both outputs are undriven. An undriven output shows drive-enable 0 and data 0.
- R2: With master enable 1 and both working enables 0, both outputs are undriven, whatever the run off-state select is.
- R3: With master enable 1 and exactly one working enable set, the enabled output is driven with (registered reference XOR its polarity bit). Polarity 0 means active high and 1 means active low. The registered reference follows ref_i one clock later.
- R4: In the case of R3, the disabled output is undriven when the run off-state select is 0. When it is 1, that output is driven at its own polarity bit.
- R5: With master enable 1 and both working enables set, both outputs are driven. The main output is active only after the registered reference has stayed high for DEAD_CYC clocks. The complementary output is active only after it has stayed low for DEAD_CYC clocks. Otherwise each output sits at its polarity bit. The two are never active together.
- R6: With master enable 0 and idle select 0, both outputs are undriven in the same cycle, combinationally.
- R7: With master enable 0 and idle select 1, both outputs are driven at once at their working polarity bits. Once DEAD_CYC rising edges have passed with that condition held, counting the first edge, they show idle_main and idle_comp.
- R8: With commutation preload 0, a write strobe sampled at edge k loads the preload bits. The working bits take them at edge k+1.
- R9: With commutation preload 1, the working bits change only at an edge where com_evt is 1. At that edge they copy the preload bits as they stood before it.
- R10: With lock_lvl 2 or 3, writes leave the main polarity bit unchanged. The complementary polarity bit is also protected at those lock levels, but only while ch_is_output is 1. The enable bits are always writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Channel reference waveform |
| moe | input | 1 | Master output enable |
| ossr | input | 1 | Run-mode off-state select |
| ossi | input | 1 | Idle-mode off-state select |
| idle_main | input | 1 | Idle level of main output |
| idle_comp | input | 1 | Idle level of complementary output |
| cfg_wr | input | 1 | Write strobe for the preload bits |
| cfg_main_en | input | 1 | Write data: main enable |
| cfg_comp_en | input | 1 | Write data: complementary enable |
| cfg_main_pol | input | 1 | Write data: main polarity |
| cfg_comp_pol | input | 1 | Write data: complementary polarity |
| ccpc | input | 1 | Commutation preload control |
| com_evt | input | 1 | Commutation pulse |
| lock_lvl | input | 2 | Write lock level 0..3 |
| ch_is_output | input | 1 | Channel configured as output |
| oc_main | output | 1 | Main output level |
| oc_comp | output | 1 | Complementary output level |
| oe_main | output | 1 | Main output drive enable |
| oe_comp | output | 1 | Complementary output drive enable |

## Verification
The control inputs moe, ossr and ossi act on the outputs in the same cycle. Reference changes show one clock later through the registered reference, and dead time adds DEAD_CYC further clocks. Configuration writes take effect two edges after the strobe, or at the commutation edge. The bench keeps a cycle model that is advanced at every rising edge from the inputs it drove. It compares all four outputs at the following falling edge, so each result is checked in the exact cycle it is due, including each step of the idle-entry countdown.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef struct packed {
    logic main_en;
    logic comp_en;
    logic main_pol;
    logic comp_pol;
  } ch_cfg_t;

  localparam int LOCK_W = 2;
  localparam logic [LOCK_W-1:0] LOCK_POL_LVL = 2'd2;
endpackage

// File: rtl/cpwm_shadow_regs.sv
module cpwm_shadow_regs
  import cpwm_pkg::*;
#(
  parameter int LW = LOCK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  ch_cfg_t       cfg_wdata,
  input  logic          ccpc,
  input  logic          com_evt,
  input  logic [LW-1:0] lock_lvl,
  input  logic          ch_is_output,
  output ch_cfg_t       pre_cfg,
  output ch_cfg_t       act_cfg
);
  logic    lock_hi;
  ch_cfg_t pre_nxt;

  assign lock_hi = (lock_lvl >= LW'(LOCK_POL_LVL));

  always_comb begin
    pre_nxt = pre_cfg;
    if (cfg_wr) begin
      pre_nxt.main_en = cfg_wdata.main_en;
      pre_nxt.comp_en = cfg_wdata.comp_en;
      if (!lock_hi)
        pre_nxt.main_pol = cfg_wdata.main_pol;
      if (!(lock_hi && ch_is_output))
        pre_nxt.comp_pol = cfg_wdata.comp_pol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cfg <= '0;
      act_cfg <= '0;
    end else begin
      pre_cfg <= pre_nxt;
      if (!ccpc || com_evt)
        act_cfg <= pre_cfg;
    end
  end
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DEAD_CYC = 4,
  localparam int CW = $clog2(DEAD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  output logic ref_q,
  output logic settled
);
  localparam logic [CW-1:0] DMAX = CW'(DEAD_CYC);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      cnt   <= DMAX;
    end else begin
      ref_q <= ref_i;
      if (ref_i != ref_q)
        cnt <= '0;
      else if (cnt < DMAX)
        cnt <= cnt + 1'b1;
    end
  end

  assign settled = (cnt == DMAX);
endmodule

// File: rtl/cpwm_idle_timer.sv
module cpwm_idle_timer #(
  parameter int DEAD_CYC = 4,
  localparam int CW = $clog2(DEAD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam logic [CW-1:0] DMAX = CW'(DEAD_CYC);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (cnt < DMAX)
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == DMAX);
endmodule

// File: rtl/cpwm_out_stage.sv
module cpwm_out_stage
  import cpwm_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_i,
  input  logic              moe,
  input  logic              ossr,
  input  logic              ossi,
  input  logic              idle_main,
  input  logic              idle_comp,
  input  logic              cfg_wr,
  input  logic              cfg_main_en,
  input  logic              cfg_comp_en,
  input  logic              cfg_main_pol,
  input  logic              cfg_comp_pol,
  input  logic              ccpc,
  input  logic              com_evt,
  input  logic [LOCK_W-1:0] lock_lvl,
  input  logic              ch_is_output,
  output logic              oc_main,
  output logic              oc_comp,
  output logic              oe_main,
  output logic              oe_comp
);
  ch_cfg_t wdata, pre_cfg, act_cfg;
  logic    ref_q, dt_settled, idle_done;

  assign wdata = '{main_en: cfg_main_en, comp_en: cfg_comp_en,
                   main_pol: cfg_main_pol, comp_pol: cfg_comp_pol};

  cpwm_shadow_regs #(.LW(LOCK_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(wdata),
    .ccpc(ccpc), .com_evt(com_evt), .lock_lvl(lock_lvl),
    .ch_is_output(ch_is_output), .pre_cfg(pre_cfg), .act_cfg(act_cfg)
  );

  cpwm_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk(clk), .rst(rst), .ref_i(ref_i), .ref_q(ref_q), .settled(dt_settled)
  );

  cpwm_idle_timer #(.DEAD_CYC(DEAD_CYC)) u_idle (
    .clk(clk), .rst(rst), .run(!moe && ossi), .done(idle_done)
  );

  always_comb begin
    oe_main = 1'b0; oc_main = 1'b0;
    oe_comp = 1'b0; oc_comp = 1'b0;
    if (!moe) begin
      if (ossi) begin
        oe_main = 1'b1;
        oe_comp = 1'b1;
        oc_main = idle_done ? idle_main : act_cfg.main_pol;
        oc_comp = idle_done ? idle_comp : act_cfg.comp_pol;
      end
    end else begin
      unique case ({act_cfg.main_en, act_cfg.comp_en})
        2'b10: begin
          oe_main = 1'b1;
          oc_main = ref_q ^ act_cfg.main_pol;
          oe_comp = ossr;
          oc_comp = ossr & act_cfg.comp_pol;
        end
        2'b01: begin
          oe_comp = 1'b1;
          oc_comp = ref_q ^ act_cfg.comp_pol;
          oe_main = ossr;
          oc_main = ossr & act_cfg.main_pol;
        end
        2'b11: begin
          oe_main = 1'b1;
          oe_comp = 1'b1;
          oc_main = (ref_q & dt_settled) ^ act_cfg.main_pol;
          oc_comp = (~ref_q & dt_settled) ^ act_cfg.comp_pol;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpwm_out_stage_chk.sv
module cpwm_out_stage_chk
  import cpwm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              moe,
  input logic              ossi,
  input logic              ccpc,
  input logic              com_evt,
  input logic              cfg_wr,
  input logic [LOCK_W-1:0] lock_lvl,
  input logic              oc_main,
  input logic              oc_comp,
  input logic              oe_main,
  input logic              oe_comp,
  input ch_cfg_t           pre_cfg,
  input ch_cfg_t           act_cfg
);
  p_none_en_r2: assert property (@(posedge clk) disable iff (rst)
    (moe && !act_cfg.main_en && !act_cfg.comp_en) |-> (!oe_main && !oe_comp));

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    (moe && act_cfg.main_en && act_cfg.comp_en)
      |-> !((oc_main ^ act_cfg.main_pol) && (oc_comp ^ act_cfg.comp_pol)));

  p_off_undriven_r6: assert property (@(posedge clk) disable iff (rst)
    (!moe && !ossi) |-> (!oe_main && !oe_comp && !oc_main && !oc_comp));

  p_idle_driven_r7: assert property (@(posedge clk) disable iff (rst)
    (!moe && ossi) |-> (oe_main && oe_comp));

  p_com_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ccpc && !com_evt) |=> $stable(act_cfg));

  p_lock_mainpol_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && lock_lvl >= 2'd2) |=> $stable(pre_cfg.main_pol));
endmodule

bind cpwm_out_stage cpwm_out_stage_chk u_chk (
  .clk(clk), .rst(rst), .moe(moe), .ossi(ossi), .ccpc(ccpc),
  .com_evt(com_evt), .cfg_wr(cfg_wr), .lock_lvl(lock_lvl),
  .oc_main(oc_main), .oc_comp(oc_comp), .oe_main(oe_main),
  .oe_comp(oe_comp), .pre_cfg(pre_cfg), .act_cfg(act_cfg)
);

// File: tb/cpwm_out_stage_tb.sv
module cpwm_out_stage_tb;
  localparam int DEAD = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ref_i = 0, moe = 0, ossr = 0, ossi = 0, idle_main = 0, idle_comp = 0;
  logic cfg_wr = 0, w_me = 0, w_ce = 0, w_mp = 0, w_cp = 0;
  logic ccpc = 0, com_evt = 0, ch_is_output = 1;
  logic [1:0] lock_lvl = 0;
  logic oc_main, oc_comp, oe_main, oe_comp;

  int total = 0, bad = 0, cyc = 0;
  string phase_tag = "";

  // bench model state: preload/active {me,ce,mp,cp}
  logic [3:0] m_pre = 0, m_act = 0;
  logic m_refq = 0;
  int m_cnt = DEAD, m_icnt = 0;

  always #4 clk = ~clk;

  cpwm_out_stage #(.DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst(rst), .ref_i(ref_i), .moe(moe), .ossr(ossr), .ossi(ossi),
    .idle_main(idle_main), .idle_comp(idle_comp), .cfg_wr(cfg_wr),
    .cfg_main_en(w_me), .cfg_comp_en(w_ce), .cfg_main_pol(w_mp),
    .cfg_comp_pol(w_cp), .ccpc(ccpc), .com_evt(com_evt), .lock_lvl(lock_lvl),
    .ch_is_output(ch_is_output), .oc_main(oc_main), .oc_comp(oc_comp),
    .oe_main(oe_main), .oe_comp(oe_comp)
  );

  always @(posedge clk) begin
    logic [3:0] np;
    cyc++;
    if (rst) begin
      m_pre = 0; m_act = 0; m_refq = 0; m_cnt = DEAD; m_icnt = 0;
    end else begin
      np = m_pre;
      if (cfg_wr) begin
        np[3] = w_me; np[2] = w_ce;
        if (lock_lvl < 2) np[1] = w_mp;
        if (!(lock_lvl >= 2 && ch_is_output)) np[0] = w_cp;
      end
      if (!ccpc || com_evt) m_act = m_pre;
      m_pre = np;
      if (ref_i != m_refq) m_cnt = 0;
      else if (m_cnt < DEAD) m_cnt++;
      m_refq = ref_i;
      if (!moe && ossi) begin
        if (m_icnt < DEAD) m_icnt++;
      end else m_icnt = 0;
    end
  end

  function automatic logic [3:0] expect_out();
    // returns {oe_main, oc_main, oe_comp, oc_comp}
    logic me, ce, mp, cp, st;
    me = m_act[3]; ce = m_act[2]; mp = m_act[1]; cp = m_act[0];
    st = (m_cnt == DEAD);
    if (!moe) begin
      if (!ossi) return 4'b0000;
      if (m_icnt == DEAD) return {1'b1, idle_main, 1'b1, idle_comp};
      return {1'b1, mp, 1'b1, cp};
    end
    case ({me, ce})
      2'b10: return {1'b1, m_refq ^ mp, ossr, ossr & cp};
      2'b01: return {ossr, ossr & mp, 1'b1, m_refq ^ cp};
      2'b11: return {1'b1, (m_refq & st) ^ mp, 1'b1, (~m_refq & st) ^ cp};
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string mode_tag();
    if (!moe) return ossi ? "R7" : "R6";
    case ({m_act[3], m_act[2]})
      2'b00: return "R2";
      2'b11: return "R5";
      default: return "R3 R4";
    endcase
  endfunction

  task automatic check_now();
    logic [3:0] got, exp;
    string tag;
    got = {oe_main, oc_main, oe_comp, oc_comp};
    exp = expect_out();
    tag = (phase_tag != "") ? phase_tag : mode_tag();
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: got oe/oc m,c=%b exp=%b", tag, cyc, got, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic wr(logic me, logic ce, logic mp, logic cp);
    cfg_wr = 1; w_me = me; w_ce = ce; w_mp = mp; w_cp = cp;
    step(1);
    cfg_wr = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    phase_tag = "R1";
    step(3);
    rst = 0;
    step(2);
    moe = 1; ossr = 1;
    step(2);                 // R1 + R2: zero enables after reset
    // R8: immediate transfer
    phase_tag = "R8";
    ref_i = 1;
    wr(1, 0, 1, 1);
    step(4);
    // R9: commutation preload
    phase_tag = "R9";
    ccpc = 1;
    wr(0, 1, 0, 0);
    step(4);
    com_evt = 1; step(1); com_evt = 0;
    step(3);
    // R10: lock protection
    phase_tag = "R10";
    ccpc = 0; lock_lvl = 2; ch_is_output = 1;
    wr(1, 1, 1, 1);
    step(3);
    ch_is_output = 0; lock_lvl = 3;
    wr(1, 0, 0, 1);
    step(3);
    wr(0, 1, 1, 0);
    step(3);
    lock_lvl = 0; ch_is_output = 1;
    wr(1, 1, 0, 1);
    step(3);
    // R5: dead time both ways
    phase_tag = "R5";
    for (int k = 0; k < 4; k++) begin
      ref_i = ~ref_i;
      step(DEAD + 3);
    end
    ref_i = ~ref_i; step(2); ref_i = ~ref_i; step(DEAD + 2);
    // R7: idle entry timing
    phase_tag = "R7";
    idle_main = 1; idle_comp = 0; ossi = 1; moe = 0;
    step(DEAD + 3);
    moe = 1; step(2); moe = 0;
    step(DEAD + 2);
    phase_tag = "R6";
    ossi = 0; step(3);
    // random mix
    phase_tag = "";
    moe = 1;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 6 == 0) ref_i = ~ref_i;
      if ($urandom % 20 == 0) moe = ~moe;
      if ($urandom % 15 == 0) ossr = $urandom;
      if ($urandom % 15 == 0) ossi = $urandom;
      if ($urandom % 25 == 0) {idle_main, idle_comp} = $urandom;
      if ($urandom % 30 == 0) ccpc = $urandom;
      com_evt = ($urandom % 10 == 0);
      if ($urandom % 30 == 0) lock_lvl = $urandom;
      if ($urandom % 30 == 0) ch_is_output = $urandom;
      cfg_wr = ($urandom % 8 == 0);
      {w_me, w_ce, w_mp, w_cp} = $urandom;
      step(1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: got running expected finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule